// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a three-wire link to a delta-sigma converter that has no latency and is run with a clock supplied from outside. A read starts with a one-cycle `start` pulse. The block lowers chip select while it holds its serial clock low, which puts the converter in externally clocked mode. It then watches the data line, where the converter shows its end-of-conversion level. Once that level is low, the block generates a programmable number of serial clock pulses, from 1 to 32, and captures one data bit on each rising edge. A read shorter than a full frame ends early when chip select goes high, and the converter then begins a new conversion.

When a read ends, the block decodes the captured frame. The first four bits carry conversion-done, a fixed zero, the sign and the extended-range flag. Then follow 24 result bits, most significant first, and 4 sub-LSB bits. The block reports a sign-extended result, over-range and under-range flags, a framing-error flag, the sub-LSB nibble and a timeout flag, all qualified by a one-cycle `res_valid` strobe.

The controller is a single state machine with these states:

| State | What it does |
|---|---|
| `ST_IDLE` | Chip select is high and the clock is low. |
| `ST_SETUP` | Chip select is low and the clock is low, for a guard of two phases. |
| `ST_POLL` | Samples the data line once per phase. |
| `ST_HIGH` | Clock high, entered with a capture. |
| `ST_LOW` | Clock low between captures. |
| `ST_HOLD` | Clock low for a guard of two phases after the last falling edge. |
| `ST_RELEASE` | Chip select is high for a guard of two phases. |

The transitions are:
- `start` in `ST_IDLE` goes to `ST_SETUP`.
- `ST_SETUP` goes to `ST_POLL` when its guard expires.
- In `ST_POLL`, a low sample goes to `ST_HIGH`, and the poll limit being reached goes to `ST_HOLD`.
- `ST_HIGH` goes to `ST_LOW` while bits remain, and to `ST_HOLD` once the count is met.
- `ST_LOW` goes to `ST_HIGH`.
- `ST_HOLD` goes to `ST_RELEASE` when its guard expires, which also fires `res_valid`.
- `ST_RELEASE` goes to `ST_IDLE` when its guard expires.

Top module: `adc_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0 and `res_valid` is 0, and they stay so until `start` is seen.
- R2: `cs_n` changes only while `sck` is low and was low in the previous cycle. After `cs_n` falls, `sck` stays low for at least two phases (2*CLK_DIV clocks) before its first rising edge.
- R3: After the setup guard, the block samples `sdo` once per phase and produces no rising `sck` edge while `sdo` reads 1 (conversion still running).
- R4: Every high phase and every low phase of `sck` lasts at least CLK_DIV clocks. The default of 13 at 50 MHz gives 260 ns phases and an `sck` rate below 2 MHz.
- R5: A read clocks exactly N rising edges and captures `sdo` on each. N is `rd_len`, and the value 0 means 32. After the N-th falling edge, `sck` stays low for two phases, then `cs_n` rises. `sck` is never high while `cs_n` is high.
- R6: Frame bits are numbered 31 (first captured) down to 0. Bit 29 is the sign (1 means non-negative) and bit 28 is the extended-range flag. The result is the 26-bit two's-complement value {~bit29, bits 28..4}, sign-extended to RES_W. When bits 29 and 28 are both 0, the result is 0.
- R7: `res_over` equals bit29 AND bit28, and `res_under` equals (NOT bit29) AND bit28. The two are never 1 together.
- R8: `res_sub` carries frame bits 3..0.
- R9: `res_frame_err` is 1 when frame bit 30 or frame bit 31 was captured as 1.
- R10: If `sdo` reads 1 on `eoc_limit`+1 consecutive polls, the read ends without any `sck` edge. `res_valid` then comes with `res_timeout`=1 and with value, flags and sub bits all 0. A limit of 0 does not time out a converter that is already done.
- R11: In a read with N < 32, frame bits that were not clocked (bits 31-N down to 0) are taken as 0 when decoding.
- R12: A `start` pulse while a read is in progress is ignored and produces no additional result.
- R13: `res_valid` is a single-cycle pulse, given while `cs_n` is already high. `cs_n` then stays high for at least two phases before it can fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a read; ignored when not idle |
| rd_len | input | 5 | Bits to clock per read, 0 meaning 32 |
| eoc_limit | input | TMO_W | Busy polls tolerated before timeout |
| cs_n | output | 1 | Active-low chip select to the converter |
| sck | output | 1 | Serial clock to the converter |
| sdo | input | 1 | Serial data and end-of-conversion level from the converter |
| res_valid | output | 1 | One-cycle strobe qualifying the result outputs |
| res_value | output | RES_W | Sign-extended conversion result |
| res_sub | output | 4 | Sub-LSB bits of the frame |
| res_over | output | 1 | Input above the reference |
| res_under | output | 1 | Input below zero |
| res_frame_err | output | 1 | Fixed-zero or conversion-done position read as 1 |
| res_timeout | output | 1 | Read abandoned because the conversion never finished |

## Verification
The bench builds the block with CLK_DIV=2, which makes a phase two clocks long. A full 32-bit read then takes only about 140 cycles, so full, truncated, single-bit, slow-conversion and timeout reads all fit in a short run. With TMO_W=12, the bench can pick both a zero poll limit and a small one of five polls, which makes the timeout path quick to reach. A converter model in the bench measures phase lengths and the guards around chip select at CLK_DIV=2. That is the smallest setting at which a phase shorter than two clocks would be visible.

// File: rtl/adc_reader_pkg.sv
package adc_reader_pkg;

    localparam int FRAME_BITS = 32;
    localparam int LEN_W      = $clog2(FRAME_BITS);
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int SUB_W      = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_POLL,
        ST_HIGH,
        ST_LOW,
        ST_HOLD,
        ST_RELEASE
    } rd_state_e;

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int CLK_DIV = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
    parameter int FRAME_BITS = 32,
    parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  shift,
    input  logic                  din,
    input  logic [CNT_W-1:0]      nbits,
    output logic [FRAME_BITS-1:0] frame
);
    logic [FRAME_BITS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear) begin
            sh_q <= '0;
        end else if (shift) begin
            sh_q <= {sh_q[FRAME_BITS-2:0], din};
        end
    end

    // Left-align the captured bits so that the first bit sits at the top.
    always_comb begin
        frame = sh_q << (CNT_W'(FRAME_BITS) - nbits);
    end
endmodule

// File: rtl/adc_status_decode.sv
module adc_status_decode #(
    parameter int FRAME_BITS = 32,
    parameter int RES_W      = 32,
    parameter int SUB_W      = 4
) (
    input  logic [FRAME_BITS-1:0] frame,
    output logic [RES_W-1:0]      value,
    output logic [SUB_W-1:0]      sub,
    output logic                  over,
    output logic                  under,
    output logic                  frame_err
);
    localparam int DONE_POS = FRAME_BITS - 1;
    localparam int ZERO_POS = FRAME_BITS - 2;
    localparam int SIGN_POS = FRAME_BITS - 3;
    localparam int XR_POS   = FRAME_BITS - 4;
    localparam int MAG_W    = FRAME_BITS - 6;

    logic             sgn;
    logic             xr;
    logic [MAG_W-1:0] raw;

    always_comb begin
        sgn       = frame[SIGN_POS];
        xr        = frame[XR_POS];
        raw       = {~sgn, frame[XR_POS:SUB_W]};
        value     = (!sgn && !xr) ? '0 : RES_W'($signed(raw));
        sub       = frame[SUB_W-1:0];
        over      = sgn & xr;
        under     = ~sgn & xr;
        frame_err = frame[ZERO_POS] | frame[DONE_POS];
    end
endmodule

// File: rtl/adc_reader.sv
module adc_reader
    import adc_reader_pkg::*;
#(
    parameter int CLK_DIV = 13,
    parameter int TMO_W   = 20,
    parameter int RES_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   rd_len,
    input  logic [TMO_W-1:0]   eoc_limit,
    output logic               cs_n,
    output logic               sck,
    input  logic               sdo,
    output logic               res_valid,
    output logic [RES_W-1:0]   res_value,
    output logic [SUB_W-1:0]   res_sub,
    output logic               res_over,
    output logic               res_under,
    output logic               res_frame_err,
    output logic               res_timeout
);
    rd_state_e state_q, state_d;

    logic                  tick;
    logic                  guard_q;
    logic [TMO_W-1:0]      poll_q;
    logic [CNT_W-1:0]      bit_q;
    logic [CNT_W-1:0]      len_q;
    logic                  tmo_q;
    logic                  capture;
    logic                  launch;
    logic [FRAME_BITS-1:0] frame;
    logic [RES_W-1:0]      dec_value;
    logic [SUB_W-1:0]      dec_sub;
    logic                  dec_over, dec_under, dec_ferr;

    adc_tick_gen #(.CLK_DIV(CLK_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state_q != ST_IDLE),
        .tick (tick)
    );

    adc_frame_shifter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) i_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(launch),
        .shift(capture),
        .din  (sdo),
        .nbits(bit_q),
        .frame(frame)
    );

    adc_status_decode #(.FRAME_BITS(FRAME_BITS), .RES_W(RES_W), .SUB_W(SUB_W)) i_dec (
        .frame    (frame),
        .value    (dec_value),
        .sub      (dec_sub),
        .over     (dec_over),
        .under    (dec_under),
        .frame_err(dec_ferr)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_SETUP;
            ST_SETUP:   if (tick && guard_q) state_d = ST_POLL;
            ST_POLL: begin
                if (tick) begin
                    if (!sdo)                     state_d = ST_HIGH;
                    else if (poll_q == eoc_limit) state_d = ST_HOLD;
                end
            end
            ST_HIGH:    if (tick) state_d = (bit_q == len_q) ? ST_HOLD : ST_LOW;
            ST_LOW:     if (tick) state_d = ST_HIGH;
            ST_HOLD:    if (tick && guard_q) state_d = ST_RELEASE;
            ST_RELEASE: if (tick && guard_q) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign launch  = (state_q == ST_IDLE) && start;
    assign capture = (state_d == ST_HIGH) && (state_q != ST_HIGH);

    // State register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            guard_q <= 1'b0;
            poll_q  <= '0;
            bit_q   <= '0;
            len_q   <= CNT_W'(FRAME_BITS);
            tmo_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) guard_q <= 1'b0;
            else if (tick)          guard_q <= ~guard_q;
            if (launch) begin
                len_q  <= (rd_len == '0) ? CNT_W'(FRAME_BITS) : CNT_W'(rd_len);
                poll_q <= '0;
                bit_q  <= '0;
                tmo_q  <= 1'b0;
            end else begin
                if (state_q == ST_POLL && tick && sdo) begin
                    if (poll_q == eoc_limit) tmo_q  <= 1'b1;
                    else                     poll_q <= poll_q + 1'b1;
                end
                if (capture) bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n          <= 1'b1;
            sck           <= 1'b0;
            res_valid     <= 1'b0;
            res_value     <= '0;
            res_sub       <= '0;
            res_over      <= 1'b0;
            res_under     <= 1'b0;
            res_frame_err <= 1'b0;
            res_timeout   <= 1'b0;
        end else begin
            cs_n      <= (state_d == ST_IDLE) || (state_d == ST_RELEASE);
            sck       <= (state_d == ST_HIGH);
            res_valid <= (state_q == ST_HOLD) && (state_d == ST_RELEASE);
            if ((state_q == ST_HOLD) && (state_d == ST_RELEASE)) begin
                res_timeout   <= tmo_q;
                res_value     <= tmo_q ? '0   : dec_value;
                res_sub       <= tmo_q ? '0   : dec_sub;
                res_over      <= tmo_q ? 1'b0 : dec_over;
                res_under     <= tmo_q ? 1'b0 : dec_under;
                res_frame_err <= tmo_q ? 1'b0 : dec_ferr;
            end
        end
    end
endmodule

// File: rtl/adc_reader_chk.sv
module adc_reader_chk #(
    parameter int CLK_DIV = 13,
    parameter int RES_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sck,
    input logic             res_valid,
    input logic [RES_W-1:0] res_value,
    input logic             res_over,
    input logic             res_under,
    input logic             res_timeout
);
    localparam int RW = $clog2(CLK_DIV + 1) + 1;
    localparam logic [RW-1:0] RUN_MIN = RW'(CLK_DIV);

    logic          sck_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            run_q <= RUN_MIN;
        end else begin
            sck_q <= sck;
            if (sck != sck_q)        run_q <= RW'(1);
            else if (run_q < RUN_MIN) run_q <= run_q + 1'b1;
        end
    end

    assert_cs_edge_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != $past(cs_n)) |-> (!sck && !$past(sck)));

    assert_phase_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != sck_q) |-> (run_q >= RUN_MIN));

    assert_sck_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_over && res_under));

    assert_timeout_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_timeout) |-> (res_value == '0 && !res_over && !res_under));

    assert_valid_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_valid_after_cs_R13: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cs_n);
endmodule

bind adc_reader adc_reader_chk #(.CLK_DIV(CLK_DIV), .RES_W(RES_W)) i_adc_reader_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck        (sck),
    .res_valid  (res_valid),
    .res_value  (res_value),
    .res_over   (res_over),
    .res_under  (res_under),
    .res_timeout(res_timeout)
);

// File: tb/test_adc_reader.sv
module test_adc_reader;
    localparam int CLK_DIV = 2;
    localparam int TMO_W   = 12;
    localparam int RES_W   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [4:0]        rd_len = '0;
    logic [TMO_W-1:0]  eoc_limit = '0;
    logic              cs_n, sck;
    logic              sdo = 1'b1;
    logic              res_valid;
    logic [RES_W-1:0]  res_value;
    logic [3:0]        res_sub;
    logic              res_over, res_under, res_frame_err, res_timeout;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    adc_reader #(.CLK_DIV(CLK_DIV), .TMO_W(TMO_W), .RES_W(RES_W)) i_adc_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_len(rd_len), .eoc_limit(eoc_limit),
        .cs_n(cs_n), .sck(sck), .sdo(sdo),
        .res_valid(res_valid), .res_value(res_value), .res_sub(res_sub),
        .res_over(res_over), .res_under(res_under), .res_frame_err(res_frame_err),
        .res_timeout(res_timeout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int cycle = 0;
    always @(posedge clk) cycle <= cycle + 1;

    logic [31:0] model_frame = '0;
    int conv_done_at = 0;
    int rises = 0, rises_busy = 0, short_phase = 0, short_gap = 0, short_cs_high = 0;
    int run = 100, gap = 0, hgap = 0, idx = 31;
    bit gap_arm = 0, hgap_arm = 0, outp = 0;
    logic sck_p = 1'b0, cs_p = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sck != sck_p) begin
                if (run < CLK_DIV) short_phase++;
                run = 1;
            end else run++;
            if (!cs_n && sck && !sck_p) begin
                rises++;
                if (!outp) rises_busy++;
            end
            if (cs_p && !cs_n) begin
                if (hgap_arm && hgap < 2*CLK_DIV) short_cs_high++;
                hgap_arm = 0; gap = 0; gap_arm = 1;
            end else if (gap_arm) begin
                if (sck && !sck_p) begin
                    if (gap < 2*CLK_DIV) short_gap++;
                    gap_arm = 0;
                end else gap++;
            end
            if (!cs_p && cs_n) begin hgap = 0; hgap_arm = 1; end
            else if (cs_n) hgap++;
            if (cs_n) begin
                outp = 0; idx = 31; sdo = 1'b1;
            end else if (!outp) begin
                if (cycle < conv_done_at) sdo = 1'b1;
                else begin outp = 1; idx = 31; sdo = model_frame[31]; end
            end else if (sck_p && !sck) begin
                idx--;
                sdo = (idx >= 0) ? model_frame[idx] : 1'b1;
            end
        end
        sck_p = sck;
        cs_p  = cs_n;
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [RES_W-1:0] value;
        logic [3:0]       sub;
        logic             over, under, ferr, tmo;
    } exp_t;
    exp_t  sb_q[$];
    string tag_q[$];
    int pushed = 0, seen = 0;

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            seen++;
            if (sb_q.size() == 0) begin
                check(1'b0, "R12", "unexpected result", 64'(res_value), 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                check(res_value == e.value, t, "value", 64'(res_value), 64'(e.value));
                check({res_sub, res_over, res_under, res_frame_err, res_timeout} ==
                      {e.sub, e.over, e.under, e.ferr, e.tmo}, t, "sub/over/under/ferr/tmo",
                      64'({res_sub, res_over, res_under, res_frame_err, res_timeout}),
                      64'({e.sub, e.over, e.under, e.ferr, e.tmo}));
            end
        end
    end

    function automatic exp_t expect_of(input logic [31:0] fr, input int n, input bit tmo);
        exp_t        e;
        logic [31:0] f;
        logic [25:0] m;
        f = tmo ? 32'd0 : (fr & ~((32'd1 << (32 - n)) - 32'd1));
        m = {~f[29], f[28:4]};
        e.value = (!f[29] && !f[28]) ? '0 : {{(RES_W-26){m[25]}}, m};
        e.sub   = f[3:0];
        e.over  = f[29] & f[28];
        e.under = ~f[29] & f[28];
        e.ferr  = f[30] | f[31];
        e.tmo   = tmo;
        return e;
    endfunction

    task automatic read_frame(input logic [31:0] frame, input int len, input int conv,
                              input int limit, input bit tmo, input bit dbl, input string tag);
        int n, r0;
        n = (len == 0) ? 32 : len;
        model_frame  = {1'b0, frame[30:0]};
        conv_done_at = cycle + conv;
        sb_q.push_back(expect_of(model_frame, n, tmo));
        tag_q.push_back(tag);
        pushed++;
        r0 = rises;
        @(negedge clk);
        rd_len = 5'(len); eoc_limit = TMO_W'(limit); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (dbl) begin
            repeat (12) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (sb_q.size() == 0);
        repeat (8 * CLK_DIV) @(negedge clk);
        check(rises - r0 == (tmo ? 0 : n), tmo ? "R10" : "R5", "sck rising edges",
              64'(rises - r0), 64'(tmo ? 0 : n));
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({cs_n, sck, res_valid} == 3'b100, "R1", "outputs in reset",
              64'({cs_n, sck, res_valid}), 64'b100);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check({cs_n, sck, res_valid} == 3'b100, "R1", "idle after reset",
              64'({cs_n, sck, res_valid}), 64'b100);

        // R6 positive in range, sub bits R8
        read_frame({4'b0010, 24'h123456, 4'hA}, 0, 0, 4, 0, 0, "R6");
        // R7 below zero: value -16
        read_frame({4'b0001, 24'hFFFFF0, 4'h5}, 0, 0, 4, 0, 0, "R7");
        // R7 above reference
        read_frame({4'b0011, 24'h000010, 4'h3}, 0, 0, 4, 0, 0, "R7");
        // R6 zero with sign 0 and range 0
        read_frame({4'b0000, 24'h000000, 4'h0}, 0, 0, 4, 0, 0, "R6");
        // R9 fixed-zero bit read as one
        read_frame({4'b0110, 24'h0000FF, 4'h1}, 0, 0, 4, 0, 0, "R9");
        // R11 truncated read of 20 bits
        read_frame({4'b0010, 24'hABCDEF, 4'h5}, 20, 0, 4, 0, 0, "R11");
        // R5 single-bit read
        read_frame({4'b0010, 24'h777777, 4'h7}, 1, 0, 4, 0, 0, "R5");
        // R11 read of 29 bits drops sub bits
        read_frame({4'b0001, 24'hE00000, 4'hF}, 29, 0, 4, 0, 0, "R11");
        // R3 slow conversion, polling before clocking
        read_frame({4'b0010, 24'h800001, 4'h9}, 0, 300, 400, 0, 0, "R3");
        // R10 zero limit with a finished conversion
        read_frame({4'b0011, 24'h0F0F0F, 4'h2}, 0, 0, 0, 0, 0, "R10");
        // R10 timeout
        read_frame({4'b0010, 24'h111111, 4'h1}, 0, 100000, 5, 1, 0, "R10");
        // R12 second start during a read
        read_frame({4'b0001, 24'hFFFFFF, 4'h4}, 0, 0, 4, 0, 1, "R12");
        repeat (100) @(negedge clk);
        check(seen == pushed, "R12", "result count", 64'(seen), 64'(pushed));

        check(rises_busy == 0, "R3", "rises while busy", 64'(rises_busy), 64'd0);
        check(short_phase == 0, "R4", "short sck phases", 64'(short_phase), 64'd0);
        check(short_gap == 0, "R2", "short cs-to-sck gaps", 64'(short_gap), 64'd0);
        check(short_cs_high == 0, "R13", "short cs high gaps", 64'(short_cs_high), 64'd0);
        summary();
    end
endmodule